// File: doc/BRIEF.md
# Windowed Watchdog with Start-up Supervision

This block supervises a microcontroller. Software serves it by writing one 9-bit trigger word through a single-cycle write strobe. The word carries an operating-mode code, a period code and a prescaler select. Because of this, every change of operating mode is also a watchdog service. The timer counts in ticks, and a tick is a fixed number of clock cycles.

After power-on, after every reset request it issues, and after a wake from fail-safe, the block enters a start-up phase. The first valid write must arrive before a start-up timeout. A missed timeout triggers a reset request and one more attempt. If the retry also times out, the block enters fail-safe.

Once a valid write has been accepted, supervision depends on the mode held from that write:
- In normal mode the block checks a window. A trigger must land in the second half of the running period.
- In every other valid mode only the expiry is checked.

Top module: `wdg_window_sup`

## Requirements
- R1: The write word holds the period code in bits [3:0], the prescaler select in bits [5:4] and the mode code in bits [8:6]. Period codes 0 to 9 are valid. A write with period code 10 to 15 raises `rst_req_o` in the cycle after the write.
- R2: Mode codes 0 to 5 are valid, and code 1 is normal mode. A write with mode code 6 or 7 raises `rst_req_o` in the cycle after the write.
- R3: The period length is (4 << period code) << prescaler select ticks. One tick is `CYC_PER_TICK` clock cycles, counted from the edge that accepted the last write.
- R4: In normal mode, a write sampled while fewer than half of the period's ticks have elapsed is too early. It raises `rst_req_o`.
- R5: In normal mode, if no valid write arrives before the tick count reaches the full period, `rst_req_o` rises at the edge where that count is reached.
- R6: A valid write inside the window restarts the timer. The new period uses the codes in that write.
- R7: In any valid mode other than normal, a valid write is accepted at any time before expiry. Expiry still raises `rst_req_o`.
- R8: `rst_req_o` stays high for exactly `RST_CYCLES` cycles. `mode_o` reads 0 from the fault onward. Writes during the pulse are ignored.
- R9: In the start-up phase, any valid write accepts the codes and ends the phase. If `STARTUP_TICKS` ticks pass without a valid write, a reset pulse is raised and one retry begins.
- R10: If the retry also reaches `STARTUP_TICKS`, `failsafe_o` rises at that edge and no reset pulse is raised.
- R11: In fail-safe, writes of any content are ignored. Only `wake_i` (or `rst_n`) clears the state, and the block then restarts the start-up phase.
- R12: `mode_o` shows the mode code of the last accepted write. It reads 0 after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wake_i | input | 1 | Leaves fail-safe when high |
| wr_en_i | input | 1 | One-cycle write strobe for the trigger word |
| wr_data_i | input | 9 | Trigger word: mode [8:6], prescaler [5:4], period [3:0] |
| rst_req_o | output | 1 | Reset request pulse |
| failsafe_o | output | 1 | High while in fail-safe |
| mode_o | output | 3 | Mode code currently in effect |

## Verification
The checker assumes the following about the inputs:
- A write strobe lasts one cycle, with the word stable during that cycle.
- `wake_i` matters only in fail-safe.
- `rst_n` is applied at time zero.

The bench meets these assumptions by driving every input on the falling edge. It raises the strobe for exactly one cycle per write and pulses `wake_i` only after it has seen `failsafe_o` high. Each window test starts from a fresh power-on reset, so the start-up phase always hands over to the tested period from a known edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int PCODE_W     = 4;
    localparam int PSEL_W      = 2;
    localparam int MODE_W      = 3;
    localparam int WDATA_W     = PCODE_W + PSEL_W + MODE_W;
    localparam int NUM_PCODES  = 10;
    localparam int NUM_MODES   = 6;
    localparam int BASE_SHIFT  = 2;
    localparam int MAX_LOG_PER = BASE_SHIFT + (NUM_PCODES - 1) + ((1 << PSEL_W) - 1);

    localparam logic [MODE_W-1:0] MODE_INIT   = 3'd0;
    localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd1;

    typedef enum logic [1:0] {
        PH_START    = 2'd0,
        PH_RUN      = 2'd1,
        PH_PULSE    = 2'd2,
        PH_FAILSAFE = 2'd3
    } phase_e;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [PSEL_W-1:0]  psel;
        logic [PCODE_W-1:0] pcode;
    } wr_word_t;
endpackage

// File: rtl/wdg_code_check.sv
module wdg_code_check
    import wdg_pkg::*;
(
    input  logic [PCODE_W-1:0] pcode_i,
    input  logic [MODE_W-1:0]  mode_i,
    output logic               valid_o
);
    always_comb begin
        valid_o = (int'(pcode_i) < NUM_PCODES) && (int'(mode_i) < NUM_MODES);
    end
endmodule

// File: rtl/wdg_period_sel.sv
module wdg_period_sel
    import wdg_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [PCODE_W-1:0] pcode_i,
    input  logic [PSEL_W-1:0]  psel_i,
    output logic [CNT_W-1:0]   period_o
);
    always_comb begin
        period_o = CNT_W'(1) << (BASE_SHIFT + int'(pcode_i) + int'(psel_i));
    end
endmodule

// File: rtl/wdg_tick_div.sv
module wdg_tick_div #(
    parameter int CYC_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DIV_W = (CYC_PER_TICK > 2) ? $clog2(CYC_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CYC_PER_TICK - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick_o = (div_q == LAST) && !clr_i;
        if (clr_i || div_q == LAST) div_d = '0;
        else                        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdg_window_sup.sv
module wdg_window_sup
    import wdg_pkg::*;
#(
    parameter int CYC_PER_TICK  = 4,
    parameter int STARTUP_TICKS = 256,
    parameter int RST_CYCLES    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_i,
    input  logic               wr_en_i,
    input  logic [WDATA_W-1:0] wr_data_i,
    output logic               rst_req_o,
    output logic               failsafe_o,
    output logic [MODE_W-1:0]  mode_o
);
    localparam int SU_W    = $clog2(STARTUP_TICKS + 1);
    localparam int CNT_W   = (MAX_LOG_PER + 1 > SU_W) ? MAX_LOG_PER + 1 : SU_W;
    localparam int PULSE_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0]   SU_LIMIT   = CNT_W'(STARTUP_TICKS);
    localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(RST_CYCLES - 1);

    typedef struct packed {
        phase_e             phase;
        logic               retry;
        logic [MODE_W-1:0]  mode;
        logic [PSEL_W-1:0]  psel;
        logic [PCODE_W-1:0] pcode;
        logic [CNT_W-1:0]   elapsed;
        logic [PULSE_W-1:0] pulse_cnt;
    } state_t;

    state_t   st_d, st_q;
    wr_word_t word;
    logic     word_ok;
    logic     tick;
    logic     accept;
    logic     div_clr;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] elapsed_inc;

    assign word = wr_word_t'(wr_data_i);

    wdg_code_check u_check (
        .pcode_i (word.pcode),
        .mode_i  (word.mode),
        .valid_o (word_ok)
    );

    wdg_period_sel #(.CNT_W(CNT_W)) u_period (
        .pcode_i  (st_q.pcode),
        .psel_i   (st_q.psel),
        .period_o (period)
    );

    wdg_tick_div #(.CYC_PER_TICK(CYC_PER_TICK)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (div_clr),
        .tick_o (tick)
    );

    always_comb begin
        st_d        = st_q;
        accept      = 1'b0;
        elapsed_inc = st_q.elapsed + CNT_W'(tick);

        case (st_q.phase)
            PH_START: begin
                if (wr_en_i) begin
                    if (word_ok) accept = 1'b1;
                    else begin
                        st_d.phase     = PH_PULSE;
                        st_d.retry     = 1'b0;
                        st_d.mode      = MODE_INIT;
                        st_d.pulse_cnt = '0;
                    end
                end else if (elapsed_inc == SU_LIMIT) begin
                    st_d.elapsed = '0;
                    st_d.mode    = MODE_INIT;
                    if (st_q.retry) begin
                        st_d.phase = PH_FAILSAFE;
                    end else begin
                        st_d.phase     = PH_PULSE;
                        st_d.retry     = 1'b1;
                        st_d.pulse_cnt = '0;
                    end
                end else begin
                    st_d.elapsed = elapsed_inc;
                end
            end
            PH_RUN: begin
                if (wr_en_i) begin
                    if (!word_ok ||
                        (st_q.mode == MODE_NORMAL && st_q.elapsed < (period >> 1))) begin
                        st_d.phase     = PH_PULSE;
                        st_d.retry     = 1'b0;
                        st_d.mode      = MODE_INIT;
                        st_d.pulse_cnt = '0;
                    end else begin
                        accept = 1'b1;
                    end
                end else if (elapsed_inc == period) begin
                    st_d.phase     = PH_PULSE;
                    st_d.retry     = 1'b0;
                    st_d.mode      = MODE_INIT;
                    st_d.pulse_cnt = '0;
                end else begin
                    st_d.elapsed = elapsed_inc;
                end
            end
            PH_PULSE: begin
                if (st_q.pulse_cnt == PULSE_LAST) begin
                    st_d.phase   = PH_START;
                    st_d.elapsed = '0;
                end else begin
                    st_d.pulse_cnt = st_q.pulse_cnt + 1'b1;
                end
            end
            default: begin
                if (wake_i) begin
                    st_d.phase   = PH_START;
                    st_d.retry   = 1'b0;
                    st_d.elapsed = '0;
                end
            end
        endcase

        if (accept) begin
            st_d.phase   = PH_RUN;
            st_d.retry   = 1'b0;
            st_d.mode    = word.mode;
            st_d.psel    = word.psel;
            st_d.pcode   = word.pcode;
            st_d.elapsed = '0;
        end

        div_clr = accept || st_q.phase == PH_PULSE || st_q.phase == PH_FAILSAFE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_START;
            st_q.retry     <= 1'b0;
            st_q.mode      <= MODE_INIT;
            st_q.psel      <= '0;
            st_q.pcode     <= '0;
            st_q.elapsed   <= '0;
            st_q.pulse_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req_o  = (st_q.phase == PH_PULSE);
    assign failsafe_o = (st_q.phase == PH_FAILSAFE);
    assign mode_o     = st_q.mode;
endmodule

// File: rtl/wdg_window_sup_chk.sv
module wdg_window_sup_chk
    import wdg_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wake_i,
    input logic               wr_en_i,
    input logic [WDATA_W-1:0] wr_data_i,
    input logic               rst_req_o,
    input logic               failsafe_o,
    input logic [MODE_W-1:0]  mode_o
);
    localparam int HW = $clog2(RST_CYCLES + 2);
    logic [HW-1:0] hi_cnt_q;
    logic          bad_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt_q <= '0;
        else if (rst_req_o) hi_cnt_q <= hi_cnt_q + 1'b1;
        else                hi_cnt_q <= '0;
    end

    assign bad_word = (wr_data_i[3:0] > 4'd9) || (wr_data_i[8:6] > 3'd5);

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> hi_cnt_q < HW'(RST_CYCLES)); // R8
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> hi_cnt_q == HW'(RST_CYCLES)); // R8
    AST_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> mode_o == 3'd0); // R8
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && bad_word && !rst_req_o && !failsafe_o) |=> rst_req_o); // R1
    AST_FS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe_o |-> !rst_req_o); // R10
    AST_FS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe_o && !wake_i) |=> (failsafe_o && $stable(mode_o))); // R11
    AST_FS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe_o && wake_i) |=> (!failsafe_o && !rst_req_o)); // R11
    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o < 3'd6); // R12
endmodule

bind wdg_window_sup wdg_window_sup_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_i     (wake_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rst_req_o  (rst_req_o),
    .failsafe_o (failsafe_o),
    .mode_o     (mode_o)
);

// File: tb/wdg_window_sup_test.sv
module wdg_window_sup_test;
    localparam int CPT = 2;
    localparam int ST  = 32;
    localparam int RC  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [8:0] wr_data_i = '0;
    logic       rst_req_o;
    logic       failsafe_o;
    logic [2:0] mode_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdg_window_sup #(.CYC_PER_TICK(CPT), .STARTUP_TICKS(ST), .RST_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rst_req_o(rst_req_o), .failsafe_o(failsafe_o),
        .mode_o(mode_o)
    );

    // vector: setup pcode[30:27], setup psel[26:25], gap[24:9], trigger word[8:0]
    localparam logic [30:0] VEC [0:8] = '{
        {4'd0, 2'd0, 16'd4,  3'd1, 2'd0, 4'd0},
        {4'd0, 2'd0, 16'd3,  3'd1, 2'd0, 4'd0},
        {4'd0, 2'd0, 16'd7,  3'd1, 2'd0, 4'd0},
        {4'd1, 2'd1, 16'd15, 3'd1, 2'd1, 4'd1},
        {4'd1, 2'd1, 16'd16, 3'd1, 2'd1, 4'd1},
        {4'd0, 2'd0, 16'd5,  3'd1, 2'd0, 4'd10},
        {4'd0, 2'd0, 16'd5,  3'd6, 2'd0, 4'd0},
        {4'd0, 2'd0, 16'd5,  3'd2, 2'd0, 4'd3},
        {4'd0, 2'd2, 16'd16, 3'd1, 2'd0, 4'd15}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] d);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic por();
        rst_n = 1'b0;
        wr_en_i = 1'b0;
        wake_i = 1'b0;
        waitn(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        por();
        chk("R12 reset mode", int'(mode_o), 0);
        chk("R8 reset rst_req", int'(rst_req_o), 0);
        chk("R11 reset failsafe", int'(failsafe_o), 0);

        // Table walk: R1 R2 R3 R4 R6
        for (int i = 0; i < 9; i++) begin
            logic [3:0] spc;
            logic [1:0] sps;
            int gap, per, exp_r, exp_m;
            logic [8:0] trig;
            spc  = VEC[i][30:27];
            sps  = VEC[i][26:25];
            gap  = int'(VEC[i][24:9]);
            trig = VEC[i][8:0];
            per  = (4 << spc) << sps;
            por();
            wr({3'd1, sps, spc});
            waitn(gap);
            wr(trig);
            exp_r = ((trig[3:0] > 4'd9) || (trig[8:6] > 3'd5) ||
                     (gap < (per / 2) * CPT)) ? 1 : 0;
            exp_m = exp_r ? 0 : int'(trig[8:6]);
            chk($sformatf("R4/R1/R2 vec %0d rst_req", i), int'(rst_req_o), exp_r);
            chk($sformatf("R6 vec %0d mode", i), int'(mode_o), exp_m);
        end

        // R5 late expiry and R8 pulse length with ignored write
        por();
        wr({3'd1, 2'd0, 4'd0});
        waitn(4 * CPT - 1);
        chk("R5 before expiry", int'(rst_req_o), 0);
        waitn(1);
        chk("R5 at expiry", int'(rst_req_o), 1);
        wr({3'd2, 2'd0, 4'd0});
        chk("R8 pulse cycle 2", int'(rst_req_o), 1);
        waitn(RC - 2);
        chk("R8 pulse last cycle", int'(rst_req_o), 1);
        waitn(1);
        chk("R8 pulse ended", int'(rst_req_o), 0);
        chk("R8 write during pulse ignored", int'(mode_o), 0);
        wr({3'd1, 2'd0, 4'd0});
        chk("R9 start-up served", int'(mode_o), 1);

        // R6 period change on a valid trigger
        por();
        wr({3'd1, 2'd0, 4'd0});
        waitn(4);
        wr({3'd1, 2'd0, 4'd1});
        waitn(8 * CPT - 1);
        chk("R6 new period not yet expired", int'(rst_req_o), 0);
        waitn(1);
        chk("R6 new period expired", int'(rst_req_o), 1);

        // R7 non-normal mode: early write accepted, expiry still checked
        por();
        wr({3'd2, 2'd0, 4'd0});
        wr({3'd2, 2'd0, 4'd0});
        chk("R7 early write accepted", int'(rst_req_o), 0);
        chk("R7 mode", int'(mode_o), 2);
        waitn(4 * CPT - 1);
        chk("R7 before expiry", int'(rst_req_o), 0);
        waitn(1);
        chk("R7 expiry", int'(rst_req_o), 1);

        // R9 R10 R11 R12 start-up retry, fail-safe, wake
        por();
        waitn(ST * CPT - 1);
        chk("R9 before start-up timeout", int'(rst_req_o), 0);
        waitn(1);
        chk("R9 start-up timeout", int'(rst_req_o), 1);
        waitn(RC);
        chk("R9 retry begins", int'(rst_req_o), 0);
        chk("R9 not fail-safe yet", int'(failsafe_o), 0);
        waitn(ST * CPT - 1);
        chk("R10 before retry timeout", int'(failsafe_o), 0);
        waitn(1);
        chk("R10 fail-safe entered", int'(failsafe_o), 1);
        chk("R10 no reset pulse", int'(rst_req_o), 0);
        wr({3'd1, 2'd0, 4'd0});
        chk("R11 valid write ignored", int'(mode_o), 0);
        chk("R11 still fail-safe", int'(failsafe_o), 1);
        wr({3'd1, 2'd0, 4'd12});
        chk("R11 bad write ignored", int'(rst_req_o), 0);
        waitn(20);
        chk("R11 held", int'(failsafe_o), 1);
        wake_i = 1'b1;
        waitn(1);
        wake_i = 1'b0;
        chk("R11 wake clears", int'(failsafe_o), 0);
        wr({3'd3, 2'd0, 4'd2});
        chk("R12 mode after wake", int'(mode_o), 3);
        chk("R11 no reset after wake", int'(rst_req_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule